// File: doc/BRIEF.md
# Core-Local Word Store with Boot Sequencer

This block holds the private word store of one processor core. The store has 512 words of 32 bits and is addressed only by whole word. The lower 496 words are plain storage. The upper 16 addresses form a window of special registers that sit in a register bank beside the storage array. Two slots of that window are input-state registers. They return the sampled pin inputs and cannot be written. The other fourteen slots are ordinary read/write registers.

A boot request starts a sequencer. It reads words `base+0` through `base+495` from shared main memory over a valid/ready read port, in ascending order, and writes each word to local address N when its acknowledge arrives. It then spends sixteen cycles clearing the special window, one slot per cycle. On the cycle after the last clear it raises a one-cycle done pulse and releases the core, which then fetches from address 0. A stop request aborts any boot and idles the core. A fresh boot request at any time restarts the sequence from address 0. The core port reads with one cycle of latency and is stalled whenever the core is not running.

Top module: `core_local_ram`

## Requirements
- R1: After reset, `busy`, `runEn`, `bootDone` and `memRdValid` are low, `coreStall` is high and `coreRdata` is zero.
- R2: A boot issues main-memory reads at addresses `base+N`, wrapping modulo 2^MAIN_AW, for N = 0..495 in ascending order. The address is held while `memRdReady` is low. The word acknowledged for N is stored at local address N.
- R3: A boot leaves every read/write special register (local addresses 496..511 except 498 and 499) reading zero.
- R4: `busy` is high from the cycle after a boot request until the boot finishes. `bootDone` is high for exactly one cycle, the first cycle in which `runEn` is high and `busy` is low.
- R5: While running, a read at general address A returns, one cycle after the access, the word most recently written there.
- R6: Address 498 reads `pinInLo` and address 499 reads `pinInHi`, both sampled at the read edge. A core write to either address is dropped.
- R7: Read/write special registers return the last value written by the core.
- R8: A stop request drives `busy`, `runEn` and `memRdValid` low on the next cycle. The core then stays idle, with no `bootDone`, until a new boot request arrives.
- R9: A boot request during a boot restarts the sequence, so the next read address is the new `base`. Words written before the restart are overwritten by the new sequence.
- R10: While `coreStall` is high, core accesses are ignored and `coreRdata` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock shared by all cores |
| rstN | input | 1 | Active-low synchronous reset |
| bootReq | input | 1 | Start or restart a boot |
| bootBase | input | MAIN_AW | Main-memory word address of image word 0 |
| stopReq | input | 1 | Abort boot or halt the core |
| memRdValid | output | 1 | Main-memory read request valid |
| memRdAddr | output | MAIN_AW | Main-memory word address |
| memRdReady | input | 1 | Acknowledge; data on memRdData is taken this cycle |
| memRdData | input | WIDTH | Main-memory read data |
| busy | output | 1 | Boot in progress |
| bootDone | output | 1 | One-cycle pulse when the boot completes |
| runEn | output | 1 | Core may execute, starting at address 0 |
| coreStall | output | 1 | Core port not accepting accesses |
| coreEn | input | 1 | Core access strobe |
| coreWe | input | 1 | Core access is a write |
| coreAddr | input | AW | Core word address |
| coreWdata | input | WIDTH | Core write data |
| coreRdata | output | WIDTH | Core read data, one cycle after the read |
| pinInLo | input | WIDTH | Pin inputs seen at address 498 |
| pinInHi | input | WIDTH | Pin inputs seen at address 499 |

## Verification
The bench uses the default parameters: 512 words of 32 bits, a 16-slot special window and a 16-bit main-memory address. With these values every image word is loaded and read back in full. One boot base sits near the top of main memory, so the address wrap in R2 is exercised. The memory model acknowledges after random delays, which covers the address-hold rule. Restart and stop requests arrive in the middle of a load.

// File: rtl/core_local_ram_pkg.sv
package core_local_ram_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_CLEAR = 2'd2,
    ST_RUN   = 2'd3
  } bootState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadWr;   // store the acknowledged main-memory word
    logic clrWr;    // zero one special slot
    logic coreGo;   // core port is live
  } ctrlStrobes_t;

endpackage

// File: rtl/core_boot_ctrl.sv
module core_boot_ctrl
  import core_local_ram_pkg::*;
#(
  parameter int AW      = 9,
  parameter int MAIN_AW = 16,
  parameter int LOADN   = 496,
  parameter int SPR     = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               bootReq,
  input  logic [MAIN_AW-1:0] bootBase,
  input  logic               stopReq,
  input  logic               memRdReady,
  output logic               memRdValid,
  output logic [MAIN_AW-1:0] memRdAddr,
  output logic               busy,
  output logic               bootDone,
  output logic               runEn,
  output ctrlStrobes_t       strobes,
  output logic [AW-1:0]      idx
);

  localparam logic [AW-1:0] LAST_LOAD = AW'(LOADN - 1);
  localparam logic [AW-1:0] LAST_CLR  = AW'(SPR - 1);

  bootState_t         state;
  logic [MAIN_AW-1:0] baseQ;
  logic               doneQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      idx   <= '0;
      baseQ <= '0;
      doneQ <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (stopReq) begin
        state <= ST_IDLE;
        idx   <= '0;
      end else if (bootReq) begin
        state <= ST_LOAD;
        idx   <= '0;
        baseQ <= bootBase;
      end else begin
        case (state)
          ST_LOAD: begin
            if (memRdReady) begin
              if (idx == LAST_LOAD) begin
                state <= ST_CLEAR;
                idx   <= '0;
              end else begin
                idx <= idx + 1'b1;
              end
            end
          end
          ST_CLEAR: begin
            if (idx == LAST_CLR) begin
              state <= ST_RUN;
              idx   <= '0;
              doneQ <= 1'b1;
            end else begin
              idx <= idx + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    memRdValid     = (state == ST_LOAD);
    memRdAddr      = baseQ + MAIN_AW'(idx);
    busy           = (state == ST_LOAD) || (state == ST_CLEAR);
    runEn          = (state == ST_RUN);
    bootDone       = doneQ;
    strobes.loadWr = (state == ST_LOAD) && memRdReady && !stopReq && !bootReq;
    strobes.clrWr  = (state == ST_CLEAR) && !stopReq && !bootReq;
    strobes.coreGo = (state == ST_RUN);
  end

endmodule

// File: rtl/core_ram_datapath.sv
module core_ram_datapath
  import core_local_ram_pkg::*;
#(
  parameter int WIDTH   = 32,
  parameter int AW      = 9,
  parameter int LOADN   = 496,
  parameter int SPR     = 16,
  parameter int RO_BASE = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  logic [AW-1:0]    idx,
  input  logic [WIDTH-1:0] memRdData,
  input  logic             coreEn,
  input  logic             coreWe,
  input  logic [AW-1:0]    coreAddr,
  input  logic [WIDTH-1:0] coreWdata,
  input  logic [WIDTH-1:0] pinInLo,
  input  logic [WIDTH-1:0] pinInHi,
  output logic [WIDTH-1:0] coreRdata
);

  localparam int SW = $clog2(SPR);
  localparam logic [AW-1:0] SPR_START = AW'(LOADN);

  logic [WIDTH-1:0] store [LOADN];
  logic [WIDTH-1:0] sprVal [SPR];
  logic             isSpr;
  logic [SW-1:0]    sprOfs;
  logic             coreWr;
  logic             coreRd;

  assign isSpr  = (coreAddr >= SPR_START);
  assign sprOfs = coreAddr[SW-1:0];
  assign coreWr = strobes.coreGo && coreEn && coreWe;
  assign coreRd = strobes.coreGo && coreEn && !coreWe;

  // general storage: one write port shared by the loader and the core
  always_ff @(posedge clk) begin
    if (strobes.loadWr)
      store[idx] <= memRdData;
    else if (coreWr && !isSpr)
      store[coreAddr] <= coreWdata;
  end

  // special window: input slots follow the pins, others are flops
  for (genvar k = 0; k < SPR; k++) begin : g_spr
    if (k == RO_BASE) begin : g_inLo
      assign sprVal[k] = pinInLo;
    end else if (k == RO_BASE + 1) begin : g_inHi
      assign sprVal[k] = pinInHi;
    end else begin : g_rw
      logic [WIDTH-1:0] regQ;
      always_ff @(posedge clk) begin
        if (!rstN)
          regQ <= '0;
        else if (strobes.clrWr && idx[SW-1:0] == SW'(k))
          regQ <= '0;
        else if (coreWr && isSpr && sprOfs == SW'(k))
          regQ <= coreWdata;
      end
      assign sprVal[k] = regQ;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      coreRdata <= '0;
    else if (coreRd)
      coreRdata <= isSpr ? sprVal[sprOfs] : store[coreAddr];
  end

endmodule

// File: rtl/core_local_ram.sv
module core_local_ram
  import core_local_ram_pkg::*;
#(
  parameter int WIDTH   = 32,
  parameter int WORDS   = 512,
  parameter int SPR     = 16,
  parameter int RO_BASE = 2,
  parameter int MAIN_AW = 16,
  localparam int AW     = $clog2(WORDS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               bootReq,
  input  logic [MAIN_AW-1:0] bootBase,
  input  logic               stopReq,
  output logic               memRdValid,
  output logic [MAIN_AW-1:0] memRdAddr,
  input  logic               memRdReady,
  input  logic [WIDTH-1:0]   memRdData,
  output logic               busy,
  output logic               bootDone,
  output logic               runEn,
  output logic               coreStall,
  input  logic               coreEn,
  input  logic               coreWe,
  input  logic [AW-1:0]      coreAddr,
  input  logic [WIDTH-1:0]   coreWdata,
  output logic [WIDTH-1:0]   coreRdata,
  input  logic [WIDTH-1:0]   pinInLo,
  input  logic [WIDTH-1:0]   pinInHi
);

  localparam int LOADN = WORDS - SPR;

  ctrlStrobes_t  strobes;
  logic [AW-1:0] idx;

  core_boot_ctrl #(
    .AW(AW), .MAIN_AW(MAIN_AW), .LOADN(LOADN), .SPR(SPR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .bootReq(bootReq), .bootBase(bootBase),
    .stopReq(stopReq), .memRdReady(memRdReady), .memRdValid(memRdValid),
    .memRdAddr(memRdAddr), .busy(busy), .bootDone(bootDone), .runEn(runEn),
    .strobes(strobes), .idx(idx)
  );

  core_ram_datapath #(
    .WIDTH(WIDTH), .AW(AW), .LOADN(LOADN), .SPR(SPR), .RO_BASE(RO_BASE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .idx(idx),
    .memRdData(memRdData), .coreEn(coreEn), .coreWe(coreWe),
    .coreAddr(coreAddr), .coreWdata(coreWdata), .pinInLo(pinInLo),
    .pinInHi(pinInHi), .coreRdata(coreRdata)
  );

  assign coreStall = !strobes.coreGo;

endmodule

// File: rtl/core_local_ram_chk.sv
module core_local_ram_chk #(
  parameter int MAIN_AW = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               bootReq,
  input logic [MAIN_AW-1:0] bootBase,
  input logic               stopReq,
  input logic               memRdValid,
  input logic [MAIN_AW-1:0] memRdAddr,
  input logic               memRdReady,
  input logic               busy,
  input logic               bootDone,
  input logic               runEn,
  input logic               coreStall
);

  AST_BUSY_NOT_RUN: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !runEn); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    bootDone |=> !bootDone); // R4
  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    bootDone |-> runEn && !busy && $past(busy)); // R4
  AST_VALID_IN_BOOT: assert property (@(posedge clk) disable iff (!rstN)
    memRdValid |-> busy); // R2
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memRdValid && !memRdReady && !bootReq && !stopReq)
      |=> memRdValid && $stable(memRdAddr)); // R2
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (memRdValid && memRdReady && !bootReq && !stopReq)
      |=> (!memRdValid || memRdAddr == $past(memRdAddr) + 1'b1)); // R2
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    stopReq |=> !busy && !runEn && !memRdValid); // R8
  AST_RESTART_BASE: assert property (@(posedge clk) disable iff (!rstN)
    (bootReq && !stopReq) |=> memRdValid && memRdAddr == $past(bootBase)); // R9
  AST_STALL_IN_BOOT: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> coreStall); // R10

endmodule

bind core_local_ram core_local_ram_chk #(.MAIN_AW(MAIN_AW)) u_chk (
  .clk(clk), .rstN(rstN), .bootReq(bootReq), .bootBase(bootBase),
  .stopReq(stopReq), .memRdValid(memRdValid), .memRdAddr(memRdAddr),
  .memRdReady(memRdReady), .busy(busy), .bootDone(bootDone),
  .runEn(runEn), .coreStall(coreStall)
);

// File: tb/core_local_ram_bench.sv
module core_local_ram_bench;

  localparam int WIDTH = 32;
  localparam int WORDS = 512;
  localparam int SPR   = 16;
  localparam int MAW   = 16;
  localparam int AW    = $clog2(WORDS);
  localparam int LOADN = WORDS - SPR;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bootReq = 1'b0, stopReq = 1'b0;
  logic [MAW-1:0] bootBase = '0;
  logic memRdValid, memRdReady = 1'b0;
  logic [MAW-1:0] memRdAddr;
  logic [WIDTH-1:0] memRdData = '0;
  logic busy, bootDone, runEn, coreStall;
  logic coreEn = 1'b0, coreWe = 1'b0;
  logic [AW-1:0] coreAddr = '0;
  logic [WIDTH-1:0] coreWdata = '0, coreRdata;
  logic [WIDTH-1:0] pinInLo = '0, pinInHi = '0;

  int checks = 0;
  int fails = 0;
  logic [MAW-1:0] expAddr;
  logic [WIDTH-1:0] shadow [WORDS];
  logic [WIDTH-1:0] expRd;
  int cycles = 0;

  always #4 clk = ~clk;

  core_local_ram u_core_local_ram (
    .clk(clk), .rstN(rstN), .bootReq(bootReq), .bootBase(bootBase),
    .stopReq(stopReq), .memRdValid(memRdValid), .memRdAddr(memRdAddr),
    .memRdReady(memRdReady), .memRdData(memRdData), .busy(busy),
    .bootDone(bootDone), .runEn(runEn), .coreStall(coreStall),
    .coreEn(coreEn), .coreWe(coreWe), .coreAddr(coreAddr),
    .coreWdata(coreWdata), .coreRdata(coreRdata), .pinInLo(pinInLo),
    .pinInHi(pinInHi)
  );

  function automatic logic [WIDTH-1:0] imageWord(input logic [MAW-1:0] a);
    return {a, ~a} ^ 32'hA5C3_0F1E;
  endfunction

  function automatic bit isInputSlot(input int a);
    return (a == LOADN + 2) || (a == LOADN + 3);
  endfunction

  task automatic check(input bit ok, input string req, input logic [WIDTH-1:0] act,
                       input logic [WIDTH-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock: memory model answers, then the edge, then sample point
  task automatic cyc();
    bit ack;
    ack = memRdValid && !bootReq && !stopReq && ($urandom % 3 != 0);
    memRdReady = ack;
    memRdData  = imageWord(memRdAddr);
    if (ack) begin
      check(memRdAddr == expAddr, "R2 read address", 32'(memRdAddr), 32'(expAddr));
      expAddr = expAddr + 1'b1;
    end
    @(negedge clk);
    cycles++;
    memRdReady = 1'b0;
  endtask

  task automatic startBoot(input logic [MAW-1:0] base);
    bootReq  = 1'b1;
    bootBase = base;
    expAddr  = base;
    cyc();
    bootReq = 1'b0;
  endtask

  task automatic finishBoot(input logic [MAW-1:0] base);
    int dones = 0;
    bit busyOk = 1'b1;
    while (!runEn && cycles < 150000) begin
      if (!busy) busyOk = 1'b0;
      cyc();
      if (bootDone) dones++;
    end
    check(busyOk, "R4 busy during boot", 32'(busyOk), 32'd1);
    check(dones == 1 && bootDone && !busy, "R4 done pulse at release",
          32'(dones), 32'd1);
    check(expAddr == base + MAW'(LOADN), "R2 word count",
          32'(expAddr - base), 32'(LOADN));
    cyc();
    check(!bootDone, "R4 done lasts one cycle", 32'(bootDone), 32'd0);
    for (int i = 0; i < WORDS; i++)
      shadow[i] = (i < LOADN) ? imageWord(base + MAW'(i)) : '0;
  endtask

  task automatic coreWrite(input int a, input logic [WIDTH-1:0] d);
    coreEn = 1'b1; coreWe = 1'b1; coreAddr = AW'(a); coreWdata = d;
    cyc();
    coreEn = 1'b0; coreWe = 1'b0;
    if (!isInputSlot(a)) shadow[a] = d;
  endtask

  task automatic coreRead(input int a, output logic [WIDTH-1:0] d);
    coreEn = 1'b1; coreWe = 1'b0; coreAddr = AW'(a);
    cyc();
    coreEn = 1'b0;
    d = coreRdata;
  endtask

  function automatic logic [WIDTH-1:0] expectAt(input int a);
    if (a == LOADN + 2) return pinInLo;
    if (a == LOADN + 3) return pinInHi;
    return shadow[a];
  endfunction

  task automatic sweep(input string req);
    int bad = 0;
    logic [WIDTH-1:0] firstAct = '0, firstExp = '0;
    logic [WIDTH-1:0] d;
    for (int a = 0; a < WORDS; a++) begin
      coreRead(a, d);
      if (d !== expectAt(a)) begin
        if (bad == 0) begin firstAct = d; firstExp = expectAt(a); end
        bad++;
      end
    end
    check(bad == 0, req, firstAct, firstExp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R4 run did not complete actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [WIDTH-1:0] d;
    logic [WIDTH-1:0] held;
    void'($urandom(32'd1357));
    @(negedge clk);
    cyc(); cyc();
    // R1 reset state
    check(!busy && !runEn && !bootDone && !memRdValid && coreStall && coreRdata == 0,
          "R1 reset outputs", {busy, runEn, bootDone, memRdValid, coreStall}, 32'b00001);
    rstN = 1'b1;
    cyc();

    // plain boot, image and special window
    pinInLo = $urandom; pinInHi = $urandom;
    startBoot(16'h0100);
    finishBoot(16'h0100);
    sweep("R2 R3 image and cleared window");

    // R6 input slots: writes dropped, reads follow pins
    coreWrite(LOADN + 2, 32'hDEAD_BEEF);
    coreWrite(LOADN + 3, 32'hFEED_F00D);
    pinInLo = 32'h1234_5678; pinInHi = 32'h9ABC_DEF0;
    coreRead(LOADN + 2, d);
    check(d == 32'h1234_5678, "R6 low input slot", d, 32'h1234_5678);
    coreRead(LOADN + 3, d);
    check(d == 32'h9ABC_DEF0, "R6 high input slot", d, 32'h9ABC_DEF0);

    // R7 special registers, R5 edge addresses
    coreWrite(LOADN, 32'h0000_00FF);
    coreWrite(WORDS - 1, 32'h8000_0001);
    coreWrite(0, 32'h1111_2222);
    coreWrite(LOADN - 1, 32'h3333_4444);
    coreRead(LOADN, d);
    check(d == 32'h0000_00FF, "R7 first special", d, 32'h0000_00FF);
    coreRead(WORDS - 1, d);
    check(d == 32'h8000_0001, "R7 last special", d, 32'h8000_0001);
    coreRead(0, d);
    check(d == 32'h1111_2222, "R5 address 0", d, 32'h1111_2222);
    coreRead(LOADN - 1, d);
    check(d == 32'h3333_4444, "R5 last general", d, 32'h3333_4444);

    // random mix of core accesses against the shadow
    for (int n = 0; n < 400; n++) begin
      int a;
      a = (n % 4 == 0) ? LOADN + int'($urandom % SPR) : int'($urandom % WORDS);
      pinInLo = $urandom; pinInHi = $urandom;
      if ($urandom % 2) coreWrite(a, $urandom);
      else begin
        coreRead(a, d);
        expRd = expectAt(a);
        check(d == expRd, a >= LOADN ? "R7 R6 random special" : "R5 random general",
              d, expRd);
      end
    end

    // R9 restart mid-load, R10 stalled read, wrap-around base
    coreRead(5, d);
    held = d;
    startBoot(16'h2000);
    repeat (60) cyc();
    coreEn = 1'b1; coreAddr = AW'(7);
    cyc();
    coreEn = 1'b0;
    check(coreRdata == held && coreStall, "R10 stalled read ignored", coreRdata, held);
    startBoot(16'hFF80);
    check(memRdValid && memRdAddr == 16'hFF80, "R9 restart at new base",
          32'(memRdAddr), 32'hFF80);
    finishBoot(16'hFF80);
    sweep("R9 R2 image after restart with wrap");

    // R8 stop mid-load
    startBoot(16'h0040);
    repeat (40) cyc();
    stopReq = 1'b1;
    cyc();
    stopReq = 1'b0;
    check(!busy && !runEn && !memRdValid, "R8 stop aborts boot",
          {busy, runEn, memRdValid}, 32'd0);
    begin
      bit quiet = 1'b1;
      for (int i = 0; i < 30; i++) begin
        cyc();
        if (busy || runEn || bootDone || memRdValid || !coreStall) quiet = 1'b0;
      end
      check(quiet, "R8 idle until next boot", 32'(quiet), 32'd1);
    end
    // R8 stop while running, then boot again
    startBoot(16'h0040);
    finishBoot(16'h0040);
    stopReq = 1'b1;
    cyc();
    stopReq = 1'b0;
    check(!runEn && coreStall, "R8 stop halts running core", 32'(runEn), 32'd0);
    startBoot(16'h0777);
    finishBoot(16'h0777);
    sweep("R3 R2 image after stop and reboot");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule